// File: doc/BRIEF.md
# Replayed-Operand Gate-Pipelined Adder

This block is a small carry-prefix adder built the way a pulse-logic circuit is built: every two-input gate owns a register clocked by the one fast clock, so each gate is a pipeline stage of its own. No registers are added to equalise paths of unequal depth. Correct results come from a different mechanism. A bank of hold registers at the adder inputs is loaded only once per macro period of `MACRO_LEN` fast cycles. Between loads it presents the same operands to the gates in every cycle. By the end of the period, every path, short or long, has settled on the same operands.

A phase counter sets the macro period. It raises the load strobe in the last cycle of each period. It raises `valid_o` for one cycle, one cycle after each load. From then on, `sum_o` and `cout_o` are correct for the operands taken at the load before. Throughput is therefore one result per `MACRO_LEN` cycles. That rate is lower than a fully balanced pipeline at the same clock, but it needs no delay registers inside the adder.

Top module: `pulse_replay_adder`

## Requirements
- R1: While `rst_n` is low, `sum_o`, `cout_o` and `valid_o` are all zero. After `rst_n` rises, `valid_o` stays low for the first 2*`MACRO_LEN` rising clock edges.
- R2: Operands `a_i`, `b_i` and `cin_i` are captured only at a rising edge that ends a cycle whose phase is `MACRO_LEN`-1. Phases count 0,1,2,... from the cycle in which reset is released. Operand values in every other cycle have no effect on any result.
- R3: Captured operands are held unchanged and presented to the gates in every cycle until the next capture.
- R4: From the second capture on, `valid_o` is high for exactly one cycle, the cycle right after each capture. It is low in all other cycles, giving one result per `MACRO_LEN` cycles.
- R5: When `valid_o` is high, {`cout_o`,`sum_o`} (carry-out as the top bit) equals `a` + `b` + `cin` of the operands captured one macro period earlier. This includes carry-in propagation and the all-ones overflow case.
- R6: `MACRO_LEN` is at least 2 + 2*ceil(log2(`WIDTH`+1)), the gate-depth bound of the prefix network including its input and sum gates.
- R7: Pulling `rst_n` low in the middle of a macro period clears the outputs at once, without waiting for a clock edge. After release, the phase sequence and the R1 start-up delay begin again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for every gate and hold register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | First operand, sampled at capture edges only |
| b_i | input | WIDTH | Second operand, sampled at capture edges only |
| cin_i | input | 1 | Carry-in, sampled at capture edges only |
| sum_o | output | WIDTH | Registered sum bits, meaningful when `valid_o` is high |
| cout_o | output | 1 | Registered carry-out, meaningful when `valid_o` is high |
| valid_o | output | 1 | One-cycle strobe marking a settled result |

## Verification
The assertions on the result take for granted that the parameter choice keeps the network depth within one macro period (R6). They also assume the operand pins carry known levels at each capture edge, since a captured unknown would be replayed for the whole period. The stimulus places real operands only in the capture cycle and drives random junk in every other cycle. This shows that off-phase values are ignored. A mid-period reset then restarts the phase sequence, and the bench realigns to it by releasing reset on a falling edge.

// File: rtl/pra_pkg.sv
package pra_pkg;

  // Function of one registered two-input gate.
  typedef enum logic [1:0] {
    GATE_AND = 2'd0,
    GATE_OR  = 2'd1,
    GATE_XOR = 2'd2
  } gate_op_e;

  // Upper bound on register stages from hold bank to outputs.
  function automatic int depth_bound(input int width);
    return 2 + 2 * $clog2(width + 1);
  endfunction

endpackage

// File: rtl/pra_gate.sv
module pra_gate
  import pra_pkg::*;
#(
  parameter gate_op_e OP = GATE_AND
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  output logic q
);

  logic q_d;

  // Next-state logic: the gate function itself.
  always_comb begin
    unique case (OP)
      GATE_AND: q_d = in_a & in_b;
      GATE_OR:  q_d = in_a | in_b;
      GATE_XOR: q_d = in_a ^ in_b;
      default:  q_d = 1'b0;
    endcase
  end

  // Every gate is its own pipeline stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

endmodule

// File: rtl/pra_phase.sv
module pra_phase #(
  parameter int MACRO_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_o,
  output logic valid_o
);

  localparam int CW = (MACRO_LEN > 1) ? $clog2(MACRO_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MACRO_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;    // at least one capture done
  logic          armed_q, armed_d;  // a full period of settled data exists

  always_comb begin
    load_o  = (cnt_q == LAST);
    cnt_d   = load_o ? '0 : cnt_q + CW'(1);
    seen_d  = seen_q | load_o;
    armed_d = armed_q | (load_o & seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end

  assign valid_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/pra_hold_bank.sv
module pra_hold_bank #(
  parameter int BITS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);

  logic [BITS-1:0] q_d;

  // Load path is gated off outside the capture cycle; reading never clears.
  always_comb begin
    q_d = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/pra_prefix_core.sv
module pra_prefix_core
  import pra_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  // Node 0 carries cin, node i+1 carries bit i.
  localparam int NODES  = WIDTH + 1;
  localparam int STAGES = $clog2(NODES);

  logic [WIDTH-1:0]             gen1;
  logic [WIDTH-1:0]             prop1;
  logic [STAGES:0][NODES-1:0]   grp;

  // Level one: per-bit generate and propagate gates.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    pra_gate #(.OP(GATE_AND)) u_gen (
      .clk(clk), .rst_n(rst_n), .in_a(op_a[i]), .in_b(op_b[i]), .q(gen1[i])
    );
    pra_gate #(.OP(GATE_XOR)) u_prop (
      .clk(clk), .rst_n(rst_n), .in_a(op_a[i]), .in_b(op_b[i]), .q(prop1[i])
    );
  end

  assign grp[0] = {gen1, cin};

  // Prefix stages at span 1, 2, 4, ...; no path equalisation anywhere.
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    localparam int D = 1 << s;
    for (genvar j = 0; j < NODES; j++) begin : g_nd
      if (j < D) begin : g_pass
        assign grp[s+1][j] = grp[s][j];
      end else begin : g_calc
        logic p_cur;
        logic t_and;
        if (s == 0) begin : g_p0
          assign p_cur = prop1[j-1];
        end else begin : g_pn
          assign p_cur = g_stg[s-1].g_nd[j].g_calc.g_pnx.p_nx;
        end

        pra_gate #(.OP(GATE_AND)) u_and (
          .clk(clk), .rst_n(rst_n), .in_a(p_cur), .in_b(grp[s][j-D]), .q(t_and)
        );
        pra_gate #(.OP(GATE_OR)) u_or (
          .clk(clk), .rst_n(rst_n), .in_a(grp[s][j]), .in_b(t_and), .q(grp[s+1][j])
        );

        // Group propagate only where a later stage still needs it.
        if (j >= 2 * D) begin : g_pnx
          logic p_far;
          logic p_nx;
          if (s == 0) begin : g_f0
            assign p_far = prop1[j-D-1];
          end else begin : g_fn
            assign p_far = g_stg[s-1].g_nd[j-D].g_calc.g_pnx.p_nx;
          end
          pra_gate #(.OP(GATE_AND)) u_pp (
            .clk(clk), .rst_n(rst_n), .in_a(p_cur), .in_b(p_far), .q(p_nx)
          );
        end
      end
    end
  end

  // Sum gates: propagate XOR incoming carry.
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    pra_gate #(.OP(GATE_XOR)) u_sx (
      .clk(clk), .rst_n(rst_n), .in_a(prop1[i]), .in_b(grp[STAGES][i]), .q(sum[i])
    );
  end

  assign cout = grp[STAGES][WIDTH];

endmodule

// File: rtl/pulse_replay_adder.sv
module pulse_replay_adder #(
  parameter int WIDTH     = 2,
  parameter int MACRO_LEN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             valid_o
);

  localparam int HB = 2 * WIDTH + 1;

  logic             load_w;
  logic [HB-1:0]    hold_q;
  logic [WIDTH-1:0] hold_a;
  logic [WIDTH-1:0] hold_b;
  logic             hold_c;

  pra_phase #(.MACRO_LEN(MACRO_LEN)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_o (load_w),
    .valid_o(valid_o)
  );

  pra_hold_bank #(.BITS(HB)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_w),
    .d    ({a_i, b_i, cin_i}),
    .q    (hold_q)
  );

  assign {hold_a, hold_b, hold_c} = hold_q;

  pra_prefix_core #(.WIDTH(WIDTH)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .op_a (hold_a),
    .op_b (hold_b),
    .cin  (hold_c),
    .sum  (sum_o),
    .cout (cout_o)
  );

endmodule

// File: rtl/pra_chk.sv
module pra_chk #(
  parameter int WIDTH     = 2,
  parameter int MACRO_LEN = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic             load,
  input logic [WIDTH-1:0] hold_a,
  input logic [WIDTH-1:0] hold_b,
  input logic             hold_c,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             valid_o
);

  localparam int RW  = WIDTH + 1;
  localparam int LIM = 2 * MACRO_LEN;
  localparam int SW  = $clog2(LIM + 1);

  logic [SW-1:0] since_rst;
  logic [SW-1:0] gap_q;
  logic          seen_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      gap_q     <= '0;
      seen_v    <= 1'b0;
    end else begin
      if (since_rst != SW'(LIM)) since_rst <= since_rst + SW'(1);
      if (valid_o) begin
        gap_q  <= '0;
        seen_v <= 1'b1;
      end else if (gap_q != SW'(LIM)) begin
        gap_q <= gap_q + SW'(1);
      end
    end
  end

  AST_FIRST_VALID_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> since_rst == SW'(LIM)); // R1

  AST_CAPTURE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> {hold_a, hold_b, hold_c} == $past({a_i, b_i, cin_i})); // R2

  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({hold_a, hold_b, hold_c})); // R3

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(load)); // R4

  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && seen_v) |-> gap_q == SW'(MACRO_LEN - 1)); // R4

  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> {cout_o, sum_o} ==
      RW'($past(hold_a)) + RW'($past(hold_b)) + RW'($past(hold_c))); // R5

endmodule

bind pulse_replay_adder pra_chk #(.WIDTH(WIDTH), .MACRO_LEN(MACRO_LEN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .load   (load_w),
  .hold_a (hold_a),
  .hold_b (hold_b),
  .hold_c (hold_c),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .valid_o(valid_o)
);

// File: tb/pulse_replay_adder_tb_top.sv
`timescale 1ns/1ps
module pulse_replay_adder_tb_top;

  localparam int W    = 2;
  localparam int P    = 6;
  localparam int NTAB = 12;
  localparam int NRND = 20;

  // Packed as {a[1:0], b[1:0], cin, expected carry-out & sum[2:0]}.
  localparam logic [7:0] VEC_TAB [NTAB] = '{
    8'b00_00_0_000, 8'b01_10_0_011, 8'b11_11_1_111, 8'b11_00_1_100,
    8'b10_10_0_100, 8'b01_01_1_011, 8'b11_01_0_100, 8'b00_11_1_100,
    8'b10_01_1_100, 8'b11_10_0_101, 8'b01_00_0_001, 8'b10_11_1_110
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         c_in;
  logic [W-1:0] sum_o;
  logic         cout_o, valid_o;

  int va [64];
  int vb [64];
  int vc [64];
  int ve [64];
  int n_chk  = 0;
  int n_fail = 0;

  pulse_replay_adder #(.WIDTH(W), .MACRO_LEN(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_i(a_in), .b_i(b_in), .cin_i(c_in),
    .sum_o(sum_o), .cout_o(cout_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Starts on the falling edge of phase 0; real operands only in phase P-1.
  task automatic run_block(input int first, input int count);
    for (int i = 0; i < count + 2; i++) begin
      for (int cy = 0; cy < P; cy++) begin
        bit exp_v;
        exp_v = (cy == 0) && (i >= 2);
        check(valid_o === exp_v, (i < 2) ? "R1 start-up valid" : "R4 valid cadence",
              int'(valid_o), int'(exp_v));
        if (exp_v) begin
          int idx;
          int got;
          idx = first + i - 2;
          got = int'({cout_o, sum_o});
          check(got == ve[idx], "R5 result (R2 capture, R3 replay)", got, ve[idx]);
        end
        if (cy == P - 1) begin
          if (i < count) begin
            a_in = W'(va[first+i]);
            b_in = W'(vb[first+i]);
            c_in = 1'(vc[first+i]);
          end else begin
            a_in = '0; b_in = '0; c_in = 1'b0;
          end
        end else begin
          a_in = W'($urandom_range(0, 3));
          b_in = W'($urandom_range(0, 3));
          c_in = 1'($urandom_range(0, 1));
        end
        @(posedge clk);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0; c_in = 1'b0;

    for (int k = 0; k < NTAB; k++) begin
      va[k] = int'(VEC_TAB[k][7:6]);
      vb[k] = int'(VEC_TAB[k][5:4]);
      vc[k] = int'(VEC_TAB[k][3]);
      ve[k] = int'(VEC_TAB[k][2:0]);
      check(ve[k] == va[k] + vb[k] + vc[k], "R5 table vs behavioural adder",
            ve[k], va[k] + vb[k] + vc[k]);
    end
    for (int k = NTAB; k < NTAB + NRND; k++) begin
      va[k] = $urandom_range(0, 3);
      vb[k] = $urandom_range(0, 3);
      vc[k] = $urandom_range(0, 1);
      ve[k] = va[k] + vb[k] + vc[k];
    end

    check(P >= 2 + 2 * $clog2(W + 1), "R6 depth bound", P, 2 + 2 * $clog2(W + 1));

    repeat (3) @(negedge clk);
    check(valid_o === 1'b0, "R1 reset valid", int'(valid_o), 0);
    check(sum_o === '0, "R1 reset sum", int'(sum_o), 0);
    check(cout_o === 1'b0, "R1 reset carry", int'(cout_o), 0);

    rst_n = 1'b1;
    run_block(0, NTAB);

    // Mid-period asynchronous reset.
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(valid_o === 1'b0, "R7 async reset valid", int'(valid_o), 0);
    check(sum_o === '0, "R7 async reset sum", int'(sum_o), 0);
    check(cout_o === 1'b0, "R7 async reset carry", int'(cout_o), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run_block(NTAB, NRND);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule